// File: doc/BRIEF.md
# Doorbell Job Mailbox Controller

This block is the device-side engine of a shared-memory job mailbox. A host places a control word, a byte length and a payload in one of four fixed areas of a word-addressed shared RAM, then sets a request bit in a 32-bit doorbell register. The controller picks one pending request, reads the area header, checks it, and moves the payload. Write requests stream payload words out to the device. Read requests pull words from a device source and place them either in the shared RAM area (pull mode) or at a host buffer address through a simple host-write request stream (push mode). Each request ends by setting exactly one OK or FAILED bit for its channel and direction in the same doorbell register.

Two channels, standard and kernel, share one sequencer. Only one request is in flight at a time. Host request bits are set by the host with write-one-to-set and cleared by the controller when it takes the request. Completion bits are cleared by the host with write-one-to-clear.

Top module: `jobbox_ctrl`

## Requirements
- R1: While reset is asserted, and after it, the doorbell register reads zero and no RAM access, stream word or host write is issued until a request arrives.
- R2: A host set affects only doorbell bits 16 to 20, and a host clear affects only bits 0 to 7; all other mask bits are ignored.
- R3: Pending requests are taken one at a time in the order kernel write (bit 19), kernel read (bit 20), standard write (bit 16), standard read (bit 17); a taken bit is cleared. Bit 18 is stored but never starts a transfer.
- R4: RAM word addresses: standard write area 0x0000, standard read area 0x4000, kernel write area 0x8000, kernel read area 0xC000; inside an area, word 0 is the control word, word 1 the byte length, payload from word 2.
- R5: A write request with control 1 and length at most 0xFFF8 bytes streams ceil(length/4) payload words in address order, marking the last word and the channel, then sets write OK (bit 0 standard, bit 4 kernel). Length 0 streams nothing and succeeds.
- R6: A write request with a control value other than 1, or a length above 0xFFF8, streams nothing and sets write FAILED (bit 1 standard, bit 5 kernel).
- R7: A read request with control 1 pops ceil(src_bytes/4) source words into payload words of the read area, then writes src_bytes into the length word, then sets read OK (bit 2 standard, bit 6 kernel).
- R8: A read request with control 2 takes the host address A from area word 2, issues host writes of the source words to A+8+4k, then src_bytes to A+4, then sets read OK; it writes nothing to the shared RAM.
- R9: A read request whose control is neither 1 nor 2, whose length exceeds 0xFFF8, or whose src_bytes exceeds the host maximum in the length word, pops nothing, writes nothing and sets read FAILED (bit 3 standard, bit 7 kernel).
- R10: Each completion raises exactly one doorbell bit among bits 0 to 7, and that bit stays set until the host clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bell_set_en | input | 1 | Host write-one-to-set strobe |
| bell_set_mask | input | 32 | Bits to set |
| bell_clr_en | input | 1 | Host write-one-to-clear strobe |
| bell_clr_mask | input | 32 | Bits to clear |
| bell_q | output | 32 | Doorbell register |
| mem_addr | output | MEM_AW | Shared RAM word address |
| mem_rd | output | 1 | RAM read, data one cycle later |
| mem_wr | output | 1 | RAM write |
| mem_wdata | output | 32 | RAM write data |
| mem_rdata | input | 32 | RAM read data |
| jo_valid | output | 1 | Write-payload stream word valid |
| jo_kern | output | 1 | Stream word belongs to the kernel channel |
| jo_last | output | 1 | Final word of the payload |
| jo_data | output | 32 | Stream word |
| src_kern | output | 1 | Channel currently served |
| src_bytes | input | LEN_W | Bytes the device has ready for a read |
| src_pop | output | 1 | Consume current source word |
| src_data | input | 32 | Current source word |
| hw_valid | output | 1 | Host write request valid |
| hw_addr | output | 32 | Host byte address |
| hw_data | output | 32 | Host write data |

## Verification
The bench builds the block with its default parameters: a 16-bit RAM word address, a 16-bit length field and a 0xFFF8-byte payload limit. With these, a kernel write of exactly 0xFFF8 bytes (16382 stream words) runs end to end, and lengths of 0xFFF9 and 0xFFFC are shown to be rejected from the header alone. The four-request collision, push-mode address arithmetic and the maximum-versus-available read check all fall inside the default area map.

// File: rtl/jobbox_pkg.sv
package jobbox_pkg;

    localparam int BELL_W   = 32;
    localparam int REQ_SWR  = 16;
    localparam int REQ_SRD  = 17;
    localparam int REQ_DBG  = 18;
    localparam int REQ_KWR  = 19;
    localparam int REQ_KRD  = 20;

    localparam logic [BELL_W-1:0] HOST_SET_MASK = 32'h001F_0000;
    localparam logic [BELL_W-1:0] HOST_CLR_MASK = 32'h0000_00FF;

    localparam logic [31:0] CTL_PULL = 32'd1;
    localparam logic [31:0] CTL_PUSH = 32'd2;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CTL,
        ST_LEN,
        ST_CHK,
        ST_WMOVE,
        ST_PADR,
        ST_PCAP,
        ST_RMOVE,
        ST_RLEN
    } seq_st_e;

endpackage

// File: rtl/jobbox_bell.sv
module jobbox_bell
    import jobbox_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic [BELL_W-1:0] set_mask,
    input  logic              clr_en,
    input  logic [BELL_W-1:0] clr_mask,
    input  logic              accept,
    input  logic [7:0]        done_set,
    output logic [BELL_W-1:0] bell_q,
    output logic              req_valid,
    output logic              req_kern,
    output logic              req_rd
);

    logic [BELL_W-1:0] bell_d;
    logic [4:0]        pick;

    always_comb begin
        req_valid = 1'b1;
        req_kern  = 1'b0;
        req_rd    = 1'b0;
        if (bell_q[REQ_KWR]) begin
            req_kern = 1'b1;
        end else if (bell_q[REQ_KRD]) begin
            req_kern = 1'b1;
            req_rd   = 1'b1;
        end else if (bell_q[REQ_SWR]) begin
            req_kern = 1'b0;
        end else if (bell_q[REQ_SRD]) begin
            req_rd   = 1'b1;
        end else begin
            req_valid = 1'b0;
        end
        pick = req_kern ? (req_rd ? 5'(REQ_KRD) : 5'(REQ_KWR))
                        : (req_rd ? 5'(REQ_SRD) : 5'(REQ_SWR));

        bell_d = bell_q;
        if (accept) bell_d[pick] = 1'b0;
        if (set_en) bell_d = bell_d | (set_mask & HOST_SET_MASK);
        if (clr_en) bell_d = bell_d & ~(clr_mask & HOST_CLR_MASK);
        bell_d[7:0] = bell_d[7:0] | done_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bell_q <= '0;
        else        bell_q <= bell_d;
    end

    p_rst_zero_r1: assert property (@(posedge clk)
        !rst_n |=> (bell_q == '0));

    p_accept_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> req_valid);

    p_dbg_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bell_q[REQ_DBG] |=> bell_q[REQ_DBG]);

    p_ok_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bell_q[0] && !(clr_en && clr_mask[0])) |=> bell_q[0]);

    p_req_not_host_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bell_q[REQ_SWR] && !accept) |=> bell_q[REQ_SWR]);

endmodule

// File: rtl/jobbox_seq.sv
module jobbox_seq
    import jobbox_pkg::*;
#(
    parameter int MEM_AW    = 16,
    parameter int LEN_W     = 16,
    parameter int MAX_BYTES = 'hFFF8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_kern,
    input  logic              req_rd,
    output logic              accept,
    output logic [7:0]        done_set,
    output logic [MEM_AW-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              jo_valid,
    output logic              jo_kern,
    output logic              jo_last,
    output logic [31:0]       jo_data,
    output logic              src_kern,
    input  logic [LEN_W-1:0]  src_bytes,
    output logic              src_pop,
    input  logic [31:0]       src_data,
    output logic              hw_valid,
    output logic [31:0]       hw_addr,
    output logic [31:0]       hw_data
);

    localparam int AREA_AW = MEM_AW - 2;

    typedef struct packed {
        seq_st_e          st;
        logic             kern;
        logic             rd;
        logic             push;
        logic [31:0]      ctl;
        logic [LEN_W-1:0] words;
        logic [LEN_W-1:0] cnt;
        logic             pend;
        logic             last;
        logic [LEN_W-1:0] rlen;
        logic [31:0]      haddr;
    } seq_s;

    seq_s q, d;
    logic [MEM_AW-1:0] base;
    logic              finish;
    logic              fail;
    logic              len_bad;

    function automatic logic [LEN_W-1:0] to_words(input logic [LEN_W-1:0] b);
        logic [LEN_W:0] s;
        s = {1'b0, b} + (LEN_W+1)'(3);
        return LEN_W'(s >> 2);
    endfunction

    always_comb begin
        d         = q;
        accept    = 1'b0;
        done_set  = '0;
        mem_addr  = '0;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_wdata = '0;
        src_pop   = 1'b0;
        hw_valid  = 1'b0;
        hw_addr   = '0;
        hw_data   = '0;
        finish    = 1'b0;
        fail      = 1'b0;
        base      = {q.kern, q.rd, AREA_AW'(0)};
        len_bad   = mem_rdata > 32'(MAX_BYTES);

        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    accept = 1'b1;
                    d.kern = req_kern;
                    d.rd   = req_rd;
                    d.st   = ST_CTL;
                end
            end
            ST_CTL: begin
                mem_rd   = 1'b1;
                mem_addr = base;
                d.st     = ST_LEN;
            end
            ST_LEN: begin
                mem_rd   = 1'b1;
                mem_addr = base + MEM_AW'(1);
                d.ctl    = mem_rdata;
                d.st     = ST_CHK;
            end
            ST_CHK: begin
                d.cnt  = '0;
                d.pend = 1'b0;
                d.last = 1'b0;
                d.push = (q.ctl == CTL_PUSH);
                if (!q.rd) begin
                    d.words = to_words(mem_rdata[LEN_W-1:0]);
                    if (q.ctl != CTL_PULL || len_bad) begin
                        finish = 1'b1;
                        fail   = 1'b1;
                    end else begin
                        d.st = ST_WMOVE;
                    end
                end else begin
                    d.words = to_words(src_bytes);
                    d.rlen  = src_bytes;
                    if ((q.ctl != CTL_PULL && q.ctl != CTL_PUSH) || len_bad ||
                        32'(src_bytes) > mem_rdata) begin
                        finish = 1'b1;
                        fail   = 1'b1;
                    end else begin
                        d.st = (q.ctl == CTL_PUSH) ? ST_PADR : ST_RMOVE;
                    end
                end
            end
            ST_WMOVE: begin
                if (q.cnt < q.words) begin
                    mem_rd   = 1'b1;
                    mem_addr = base + MEM_AW'(2) + MEM_AW'(q.cnt);
                    d.cnt    = q.cnt + LEN_W'(1);
                    d.pend   = 1'b1;
                    d.last   = (q.cnt + LEN_W'(1)) == q.words;
                end else begin
                    d.pend = 1'b0;
                    if (!q.pend) finish = 1'b1;
                end
            end
            ST_PADR: begin
                mem_rd   = 1'b1;
                mem_addr = base + MEM_AW'(2);
                d.st     = ST_PCAP;
            end
            ST_PCAP: begin
                d.haddr = mem_rdata;
                d.st    = ST_RMOVE;
            end
            ST_RMOVE: begin
                if (q.cnt < q.words) begin
                    src_pop = 1'b1;
                    if (q.push) begin
                        hw_valid = 1'b1;
                        hw_addr  = q.haddr + 32'd8 + (32'(q.cnt) << 2);
                        hw_data  = src_data;
                    end else begin
                        mem_wr    = 1'b1;
                        mem_addr  = base + MEM_AW'(2) + MEM_AW'(q.cnt);
                        mem_wdata = src_data;
                    end
                    d.cnt = q.cnt + LEN_W'(1);
                end else begin
                    d.st = ST_RLEN;
                end
            end
            ST_RLEN: begin
                if (q.push) begin
                    hw_valid = 1'b1;
                    hw_addr  = q.haddr + 32'd4;
                    hw_data  = 32'(q.rlen);
                end else begin
                    mem_wr    = 1'b1;
                    mem_addr  = base + MEM_AW'(1);
                    mem_wdata = 32'(q.rlen);
                end
                finish = 1'b1;
            end
            default: d.st = ST_IDLE;
        endcase

        if (finish) begin
            done_set = 8'(1) << {q.kern, q.rd, fail};
            d.st     = ST_IDLE;
            d.pend   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign jo_valid = q.pend;
    assign jo_last  = q.pend & q.last;
    assign jo_kern  = q.kern;
    assign jo_data  = mem_rdata;
    assign src_kern = q.kern;

    p_one_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done_set));

    p_ram_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    p_stream_alone_r5: assert property (@(posedge clk) disable iff (!rst_n)
        jo_valid |-> (!src_pop && !hw_valid));

    p_pop_has_dest_r7: assert property (@(posedge clk) disable iff (!rst_n)
        src_pop |-> (mem_wr || hw_valid));

    p_push_no_ram_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hw_valid |-> !mem_wr);

endmodule

// File: rtl/jobbox_ctrl.sv
module jobbox_ctrl
    import jobbox_pkg::*;
#(
    parameter int MEM_AW    = 16,
    parameter int LEN_W     = 16,
    parameter int MAX_BYTES = 'hFFF8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bell_set_en,
    input  logic [31:0]       bell_set_mask,
    input  logic              bell_clr_en,
    input  logic [31:0]       bell_clr_mask,
    output logic [31:0]       bell_q,
    output logic [MEM_AW-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              jo_valid,
    output logic              jo_kern,
    output logic              jo_last,
    output logic [31:0]       jo_data,
    output logic              src_kern,
    input  logic [LEN_W-1:0]  src_bytes,
    output logic              src_pop,
    input  logic [31:0]       src_data,
    output logic              hw_valid,
    output logic [31:0]       hw_addr,
    output logic [31:0]       hw_data
);

    logic       req_valid;
    logic       req_kern;
    logic       req_rd;
    logic       accept;
    logic [7:0] done_set;

    jobbox_bell u_bell (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_en    (bell_set_en),
        .set_mask  (bell_set_mask),
        .clr_en    (bell_clr_en),
        .clr_mask  (bell_clr_mask),
        .accept    (accept),
        .done_set  (done_set),
        .bell_q    (bell_q),
        .req_valid (req_valid),
        .req_kern  (req_kern),
        .req_rd    (req_rd)
    );

    jobbox_seq #(
        .MEM_AW    (MEM_AW),
        .LEN_W     (LEN_W),
        .MAX_BYTES (MAX_BYTES)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_kern  (req_kern),
        .req_rd    (req_rd),
        .accept    (accept),
        .done_set  (done_set),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .jo_valid  (jo_valid),
        .jo_kern   (jo_kern),
        .jo_last   (jo_last),
        .jo_data   (jo_data),
        .src_kern  (src_kern),
        .src_bytes (src_bytes),
        .src_pop   (src_pop),
        .src_data  (src_data),
        .hw_valid  (hw_valid),
        .hw_addr   (hw_addr),
        .hw_data   (hw_data)
    );

endmodule

// File: tb/jobbox_ctrl_tb_top.sv
`timescale 1ns/1ps
module jobbox_ctrl_tb_top;

    localparam int MEM_AW = 16;
    localparam int LEN_W  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bell_set_en = 1'b0;
    logic [31:0]       bell_set_mask = '0;
    logic              bell_clr_en = 1'b0;
    logic [31:0]       bell_clr_mask = '0;
    logic [31:0]       bell_q;
    logic [MEM_AW-1:0] mem_addr;
    logic              mem_rd, mem_wr;
    logic [31:0]       mem_wdata;
    logic [31:0]       mem_rdata = '0;
    logic              jo_valid, jo_kern, jo_last;
    logic [31:0]       jo_data;
    logic              src_kern;
    logic [LEN_W-1:0]  src_bytes = '0;
    logic              src_pop;
    logic [31:0]       src_data = '0;
    logic              hw_valid;
    logic [31:0]       hw_addr, hw_data;

    always #10 clk = ~clk;

    jobbox_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .bell_set_en(bell_set_en), .bell_set_mask(bell_set_mask),
        .bell_clr_en(bell_clr_en), .bell_clr_mask(bell_clr_mask),
        .bell_q(bell_q),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .jo_valid(jo_valid), .jo_kern(jo_kern), .jo_last(jo_last), .jo_data(jo_data),
        .src_kern(src_kern), .src_bytes(src_bytes), .src_pop(src_pop), .src_data(src_data),
        .hw_valid(hw_valid), .hw_addr(hw_addr), .hw_data(hw_data)
    );

    int errors = 0;
    int checks = 0;
    int rd_cnt = 0, wr_cnt = 0, pop_cnt = 0, jo_cnt = 0;
    logic [31:0] mem [int];
    logic [31:0] src_q [$];
    logic [33:0] exp_jo [$];
    logic [63:0] exp_hw [$];
    logic [7:0]  rise_log [$];
    logic [7:0]  prev_low = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rd_word(input int a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    function automatic void src_refresh();
        src_data = (src_q.size() > 0) ? src_q[0] : 32'h0;
    endfunction

    // RAM and source models
    always @(posedge clk) begin
        if (mem_rd) begin
            mem_rdata <= rd_word(int'(mem_addr));
            rd_cnt++;
        end
        if (mem_wr) begin
            mem[int'(mem_addr)] = mem_wdata;
            wr_cnt++;
        end
        if (src_pop) begin
            pop_cnt++;
            if (src_q.size() > 0) void'(src_q.pop_front());
            src_refresh();
        end
    end

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (jo_valid) begin
                jo_cnt++;
                if (exp_jo.size() == 0) begin
                    chk(1'b0, "R5", "unexpected stream word", {31'b0, jo_kern, jo_last, jo_data}, 64'h0);
                end else begin
                    logic [33:0] e;
                    e = exp_jo.pop_front();
                    chk({jo_kern, jo_last, jo_data} == e, "R5", "stream word",
                        {30'b0, jo_kern, jo_last, jo_data}, {30'b0, e});
                end
            end
            if (hw_valid) begin
                if (exp_hw.size() == 0) begin
                    chk(1'b0, "R8", "unexpected host write", {hw_addr, hw_data}, 64'h0);
                end else begin
                    logic [63:0] h;
                    h = exp_hw.pop_front();
                    chk({hw_addr, hw_data} == h, "R8", "host write", {hw_addr, hw_data}, h);
                end
            end
            if ((bell_q[7:0] & ~prev_low) != 8'h0) begin
                rise_log.push_back(bell_q[7:0] & ~prev_low);
                chk($countones(bell_q[7:0] & ~prev_low) == 1, "R10", "single result bit",
                    64'(bell_q[7:0] & ~prev_low), 64'h1);
            end
            prev_low = bell_q[7:0];
        end
    end

    task automatic ring(input logic [31:0] m);
        @(negedge clk);
        bell_set_en = 1'b1; bell_set_mask = m;
        @(negedge clk);
        bell_set_en = 1'b0; bell_set_mask = '0;
    endtask

    task automatic hclr(input logic [31:0] m);
        @(negedge clk);
        bell_clr_en = 1'b1; bell_clr_mask = m;
        @(negedge clk);
        bell_clr_en = 1'b0; bell_clr_mask = '0;
    endtask

    task automatic wait_low(input logic [7:0] want, input string req, output logic [7:0] got);
        int n = 0;
        while (((bell_q[7:0] & want) != want) && (bell_q[7:0] == 8'h0 || want != 8'h0) && n < 20000) begin
            @(negedge clk);
            n++;
            if (want == 8'h0 && bell_q[7:0] != 8'h0) break;
        end
        repeat (3) @(negedge clk);
        got = bell_q[7:0];
        if (n >= 20000) chk(1'b0, req, "completion timeout", 64'(got), 64'(want));
    endtask

    task automatic set_area(input int b, input logic [31:0] ctl, input logic [31:0] len);
        mem[b] = ctl;
        mem[b + 1] = len;
    endtask

    task automatic src_push(input logic [31:0] w);
        src_q.push_back(w);
        src_refresh();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "WDOG", "watchdog expired", 64'h0, 64'h1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] got;
        int j0, p0, w0, r0;

        repeat (4) @(negedge clk);
        chk(bell_q == 32'h0, "R1", "doorbell in reset", 64'(bell_q), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(bell_q == 32'h0 && !mem_rd && !mem_wr && !jo_valid && !hw_valid && !src_pop,
            "R1", "idle after reset", {32'(mem_rd), bell_q}, 64'h0);

        // R2 / R3: out-of-range set bits ignored, debug bit stored but idle
        r0 = rd_cnt;
        ring(32'hFFE4_FFFF);
        chk(bell_q == 32'h0004_0000, "R2", "set mask filtering", 64'(bell_q), 64'h0004_0000);
        repeat (20) @(negedge clk);
        chk(rd_cnt == r0, "R3", "debug bit starts nothing", 64'(rd_cnt - r0), 64'h0);
        hclr(32'hFFFF_FFFF);
        chk(bell_q == 32'h0004_0000, "R2", "clear mask filtering", 64'(bell_q), 64'h0004_0000);

        // R5/R4: standard write, 10 bytes -> 3 words
        set_area(32'h0000, 32'd1, 32'd10);
        mem[2] = 32'hA000_0001; mem[3] = 32'hA000_0002; mem[4] = 32'hA000_0003;
        exp_jo.push_back({2'b00, 32'hA000_0001});
        exp_jo.push_back({2'b00, 32'hA000_0002});
        exp_jo.push_back({2'b01, 32'hA000_0003});
        ring(32'h0001_0000);
        wait_low(8'h01, "R5", got);
        chk(got == 8'h01, "R5", "std write OK bit", 64'(got), 64'h01);
        chk(exp_jo.size() == 0, "R5", "all std words streamed", 64'(exp_jo.size()), 64'h0);
        chk(bell_q[16] == 1'b0, "R3", "taken request cleared", 64'(bell_q[16]), 64'h0);
        hclr(32'h0000_00FF);
        chk(bell_q == 32'h0004_0000, "R2", "host clears result bit", 64'(bell_q), 64'h0004_0000);

        // R5/R4: kernel write, 8 bytes
        set_area(32'h8000, 32'd1, 32'd8);
        mem[32'h8002] = 32'hB0B0_0001; mem[32'h8003] = 32'hB0B0_0002;
        exp_jo.push_back({2'b10, 32'hB0B0_0001});
        exp_jo.push_back({2'b11, 32'hB0B0_0002});
        ring(32'h0008_0000);
        wait_low(8'h10, "R5", got);
        chk(got == 8'h10, "R5", "kern write OK bit", 64'(got), 64'h10);
        chk(exp_jo.size() == 0, "R4", "kern area words streamed", 64'(exp_jo.size()), 64'h0);
        hclr(32'hFF);

        // R6: push control on a write area
        set_area(32'h0000, 32'd2, 32'd4);
        j0 = jo_cnt;
        ring(32'h0001_0000);
        wait_low(8'h02, "R6", got);
        chk(got == 8'h02, "R6", "write ctl 2 fails", 64'(got), 64'h02);
        chk(jo_cnt == j0, "R6", "no stream on bad ctl", 64'(jo_cnt - j0), 64'h0);
        hclr(32'hFF);

        // R6: length too large
        set_area(32'h0000, 32'd1, 32'h0000_FFFC);
        ring(32'h0001_0000);
        wait_low(8'h02, "R6", got);
        chk(got == 8'h02, "R6", "std length 0xFFFC fails", 64'(got), 64'h02);
        hclr(32'hFF);
        set_area(32'h8000, 32'd1, 32'h0000_FFF9);
        ring(32'h0008_0000);
        wait_low(8'h20, "R6", got);
        chk(got == 8'h20, "R6", "kern length 0xFFF9 fails", 64'(got), 64'h20);
        chk(jo_cnt == j0, "R6", "no stream on long length", 64'(jo_cnt - j0), 64'h0);
        hclr(32'hFF);

        // R5: zero length
        set_area(32'h0000, 32'd1, 32'd0);
        ring(32'h0001_0000);
        wait_low(8'h01, "R5", got);
        chk(got == 8'h01, "R5", "zero length OK", 64'(got), 64'h01);
        chk(jo_cnt == j0, "R5", "zero length streams nothing", 64'(jo_cnt - j0), 64'h0);
        hclr(32'hFF);

        // R5: maximum length 0xFFF8 on the kernel channel
        set_area(32'h8000, 32'd1, 32'h0000_FFF8);
        for (int i = 0; i < 16382; i++) begin
            mem[32'h8002 + i] = 32'h5A00_0000 + 32'(i * 7);
            exp_jo.push_back({1'b1, (i == 16381), 32'h5A00_0000 + 32'(i * 7)});
        end
        ring(32'h0008_0000);
        wait_low(8'h10, "R5", got);
        chk(got == 8'h10, "R5", "max length OK", 64'(got), 64'h10);
        chk(jo_cnt - j0 == 16382, "R5", "max length word count", 64'(jo_cnt - j0), 64'd16382);
        hclr(32'hFF);

        // R7: pull read, 11 bytes ready, max 16
        set_area(32'h4000, 32'd1, 32'd16);
        src_push(32'hC000_0001); src_push(32'hC000_0002); src_push(32'hC000_0003);
        src_bytes = 16'd11;
        p0 = pop_cnt;
        ring(32'h0002_0000);
        wait_low(8'h04, "R7", got);
        chk(got == 8'h04, "R7", "pull read OK bit", 64'(got), 64'h04);
        chk(pop_cnt - p0 == 3, "R7", "pop count", 64'(pop_cnt - p0), 64'd3);
        chk(rd_word(32'h4002) == 32'hC000_0001 && rd_word(32'h4003) == 32'hC000_0002 &&
            rd_word(32'h4004) == 32'hC000_0003, "R7", "payload in read area",
            64'(rd_word(32'h4004)), 64'hC000_0003);
        chk(rd_word(32'h4001) == 32'd11, "R7", "length written back", 64'(rd_word(32'h4001)), 64'd11);
        hclr(32'hFF);

        // R8: push read on kernel channel
        set_area(32'hC000, 32'd2, 32'd100);
        mem[32'hC002] = 32'h1000_0000;
        src_push(32'hD000_0001); src_push(32'hD000_0002);
        src_bytes = 16'd6;
        exp_hw.push_back({32'h1000_0008, 32'hD000_0001});
        exp_hw.push_back({32'h1000_000C, 32'hD000_0002});
        exp_hw.push_back({32'h1000_0004, 32'd6});
        w0 = wr_cnt;
        ring(32'h0010_0000);
        wait_low(8'h40, "R8", got);
        chk(got == 8'h40, "R8", "push read OK bit", 64'(got), 64'h40);
        chk(exp_hw.size() == 0, "R8", "all host writes seen", 64'(exp_hw.size()), 64'h0);
        chk(wr_cnt == w0, "R8", "no RAM writes in push", 64'(wr_cnt - w0), 64'h0);
        chk(rd_word(32'hC001) == 32'd100, "R8", "RAM length untouched", 64'(rd_word(32'hC001)), 64'd100);
        hclr(32'hFF);

        // R9: available exceeds maximum
        set_area(32'h4000, 32'd1, 32'd16);
        src_bytes = 16'd20;
        p0 = pop_cnt; w0 = wr_cnt;
        ring(32'h0002_0000);
        wait_low(8'h08, "R9", got);
        chk(got == 8'h08, "R9", "oversize read fails", 64'(got), 64'h08);
        chk(pop_cnt == p0 && wr_cnt == w0, "R9", "nothing moved on fail",
            64'(pop_cnt - p0 + wr_cnt - w0), 64'h0);
        chk(rd_word(32'h4001) == 32'd16, "R9", "length word kept", 64'(rd_word(32'h4001)), 64'd16);
        hclr(32'hFF);
        set_area(32'hC000, 32'd3, 32'd16);
        src_bytes = 16'd4;
        ring(32'h0010_0000);
        wait_low(8'h80, "R9", got);
        chk(got == 8'h80, "R9", "bad read ctl fails", 64'(got), 64'h80);
        hclr(32'hFF);

        // R3: all four requests together
        set_area(32'h0000, 32'd1, 32'd4); mem[2] = 32'h5151_0000;
        set_area(32'h4000, 32'd1, 32'd16);
        set_area(32'h8000, 32'd1, 32'd4); mem[32'h8002] = 32'hCACA_0000;
        set_area(32'hC000, 32'd1, 32'd16);
        src_push(32'hE000_0001); src_push(32'hE000_0002);
        src_bytes = 16'd4;
        exp_jo.push_back({2'b11, 32'hCACA_0000});
        exp_jo.push_back({2'b01, 32'h5151_0000});
        rise_log.delete();
        ring(32'h001B_0000);
        wait_low(8'h55, "R3", got);
        chk(got == 8'h55, "R3", "all four completed", 64'(got), 64'h55);
        chk(rise_log.size() == 4, "R3", "four separate completions", 64'(rise_log.size()), 64'd4);
        if (rise_log.size() == 4) begin
            chk({rise_log[0], rise_log[1], rise_log[2], rise_log[3]} == 32'h1040_0104,
                "R3", "completion order", 64'({rise_log[0], rise_log[1], rise_log[2], rise_log[3]}),
                64'h1040_0104);
        end
        chk(rd_word(32'hC002) == 32'hE000_0001 && rd_word(32'h4002) == 32'hE000_0002,
            "R3", "kernel read served before standard read", 64'(rd_word(32'hC002)), 64'hE000_0001);
        chk(exp_jo.size() == 0, "R3", "write streams done", 64'(exp_jo.size()), 64'h0);
        hclr(32'hFF);
        chk(bell_q == 32'h0004_0000, "R10", "bits held until cleared", 64'(bell_q), 64'h0004_0000);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule